// File: doc/BRIEF.md
# Vector rounding shift-accumulate unit

This block is the arithmetic core of a single vector operation. A wide input vector is cut into independent 16-bit unsigned lanes. In every lane, a source element is shifted right by a shared immediate, with round-half-up rounding. The rounded value is then added to the matching accumulator element. All lanes use the same immediate, and one result vector is produced per accepted input.

Rounding works by adding half the weight of the shift before the shift is done. The sum is kept at 17 bits, so the rounding carry is never lost. This gives the same value as a plain logical shift that is bumped by one whenever the highest discarded bit is set.

The accumulate step wraps modulo 2^16. An immediate outside the legal range 1..16 raises an error flag, and that beat passes the accumulator through unchanged.

The vector width is a parameter and must be a whole multiple of 128 bits (8 to 128 lanes for 128 to 2048 bits). Any other width is refused at elaboration.

Top module: `vrsa_unit`

## Requirements
- R1: With a legal immediate sh (1..16), each lane of out_vec equals (acc + ((src + 2^(sh-1)) >> sh)) mod 2^16. The sum inside the brackets is formed at 17 bits. The value appears on the clock edge after the edge that samples in_valid high.
- R2: With sh = 16, a lane result is acc + 1 when the source lane is 0x8000 or greater, and acc + 0 otherwise.
- R3: The accumulate wraps modulo 2^16 with no saturation. For example, acc 0xFFFF plus a rounded value of 1 gives 0x0000.
- R4: When in_valid is high and shamt is 0 or any value from 17 to 31, out_err is 1 and out_vec equals acc_vec unchanged on the following cycle.
- R5: out_valid equals in_valid delayed by one cycle. out_err is 1 only in a cycle where out_valid is 1.
- R6: A synchronous active-high reset clears out_valid, out_err and out_vec to zero, including while a beat is in flight.
- R7: In a cycle where in_valid is low, out_vec keeps its previous value and ignores acc_vec, src_vec and shamt.
- R8: Lane i occupies bits [16*i+15 : 16*i] of every vector port. Each lane's result depends only on that lane's inputs and the shared shamt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat strobe |
| acc_vec | input | VEC_W | Accumulator lanes |
| src_vec | input | VEC_W | Source lanes to be shifted |
| shamt | input | 5 | Shift immediate, legal 1..16 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_err | output | 1 | Illegal immediate seen on this beat |
| out_vec | output | VEC_W | Registered result lanes |

## Verification
The bench targets four kinds of failure:

- **Rounding carry.** It drives all-ones sources at every shift from 1 to 16. A design that drops the rounding carry by forming the sum at 16 bits would return acc + 0 at shift 16, where acc + 1 is correct.
- **Wraparound.** Accumulators near 0xFFFF are used to expose any saturation or extra carry bit.
- **Illegal immediates.** Shifts of 0, 17 and 31 check that the accumulator passes through with the error flag raised. A design that shifted anyway would alter the lanes.
- **Idle and reset cycles.** Idle beats with changing inputs, and a reset that lands during a beat, would catch a result register that loads without in_valid or survives reset.

// File: rtl/vrsa_pkg.sv
`timescale 1ns/1ps
package vrsa_pkg;
    localparam int LANE_W    = 16;
    localparam int SUM_W     = LANE_W + 1;
    localparam int SH_W      = 5;
    localparam int SH_MIN    = 1;
    localparam int SH_MAX    = 16;
    localparam int WIDTH_GRAIN = 128;

    function automatic logic shift_is_legal(input logic [SH_W-1:0] sh);
        return (int'(sh) >= SH_MIN) && (int'(sh) <= SH_MAX);
    endfunction
endpackage

// File: rtl/vrsa_imm_check.sv
`timescale 1ns/1ps
module vrsa_imm_check
    import vrsa_pkg::*;
(
    input  logic [SH_W-1:0] shamt_i,
    output logic            ok_o
);
    always_comb begin
        ok_o = shift_is_legal(shamt_i);
    end

    // R4: the legal window is exactly 1..16
    always_comb begin
        if (shamt_i == '0)
            assert_zero_illegal_R4: assert (!ok_o);
    end
endmodule

// File: rtl/vrsa_lane.sv
`timescale 1ns/1ps
module vrsa_lane
    import vrsa_pkg::*;
(
    input  logic [LANE_W-1:0] acc_i,
    input  logic [LANE_W-1:0] src_i,
    input  logic [SH_W-1:0]   sh_i,
    output logic [LANE_W-1:0] sum_o
);
    logic [SUM_W-1:0]  half_w;
    logic [SUM_W-1:0]  biased;
    logic [SUM_W-1:0]  shifted;
    logic [LANE_W-1:0] rounded;

    always_comb begin
        half_w  = SUM_W'(1) << (sh_i - SH_W'(1));
        biased  = {1'b0, src_i} + half_w;
        shifted = biased >> sh_i;
        rounded = shifted[LANE_W-1:0];
        sum_o   = acc_i + rounded;
    end

    // R1: biased-then-shift equals plain shift plus top discarded bit
    always_comb begin
        if (shift_is_legal(sh_i))
            assert_round_equiv_R1: assert (rounded ==
                (LANE_W'(src_i >> sh_i) + LANE_W'(src_i[sh_i - SH_W'(1)])));
    end
endmodule

// File: rtl/vrsa_unit.sv
`timescale 1ns/1ps
module vrsa_unit
    import vrsa_pkg::*;
#(
    parameter int VEC_W = 512
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] acc_vec,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [SH_W-1:0]  shamt,
    output logic             out_valid,
    output logic             out_err,
    output logic [VEC_W-1:0] out_vec
);
    localparam int LANES = VEC_W / LANE_W;

    if ((VEC_W % WIDTH_GRAIN) != 0 || VEC_W == 0) begin : g_bad_width
        $fatal(1, "vrsa_unit: VEC_W must be a nonzero multiple of 128");
    end

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t           st_d, st_q;
    logic             imm_ok;
    logic [VEC_W-1:0] lane_sum;

    vrsa_imm_check u_imm (
        .shamt_i (shamt),
        .ok_o    (imm_ok)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vrsa_lane u_lane (
            .acc_i (acc_vec[i*LANE_W +: LANE_W]),
            .src_i (src_vec[i*LANE_W +: LANE_W]),
            .sh_i  (shamt),
            .sum_o (lane_sum[i*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.err   = in_valid && !imm_ok;
        if (in_valid)
            st_d.vec = imm_ok ? lane_sum : acc_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_err   = st_q.err;
    assign out_vec   = st_q.vec;

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_err_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid);
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec));
    assert_bad_imm_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (shamt == '0 || int'(shamt) > SH_MAX))
        |=> (out_err && out_vec == $past(acc_vec)));
endmodule

// File: tb/vrsa_unit_bench.sv
`timescale 1ns/1ps
module vrsa_unit_bench;
    localparam int W  = 256;
    localparam int NL = W / 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] acc_vec = '0;
    logic [W-1:0] src_vec = '0;
    logic [4:0]   shamt = 5'd1;
    logic         out_valid, out_err;
    logic [W-1:0] out_vec;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    vrsa_unit #(.VEC_W(W)) u_vrsa_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .acc_vec(acc_vec), .src_vec(src_vec), .shamt(shamt),
        .out_valid(out_valid), .out_err(out_err), .out_vec(out_vec)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                           input logic [W-1:0] s,
                                           input logic [4:0] sh);
        logic [W-1:0] r;
        for (int i = 0; i < NL; i++) begin
            longint av = longint'(a[16*i +: 16]);
            longint sv = longint'(s[16*i +: 16]);
            longint rv;
            if (sh < 1 || sh > 16) rv = av;
            else rv = (av + ((sv + (longint'(1) << (sh - 1))) >> sh)) & 64'hFFFF;
            r[16*i +: 16] = rv[15:0];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one beat, wait one edge, sample after it
    task automatic beat(input string req, input logic [W-1:0] a,
                        input logic [W-1:0] s, input logic [4:0] sh);
        @(negedge clk);
        in_valid = 1'b1; acc_vec = a; src_vec = s; shamt = sh;
        @(posedge clk); #1;
        check_bit({req, " valid"}, out_valid, 1'b1);
        check_bit({req, " err"}, out_err, (sh < 1 || sh > 16));
        check_vec(req, out_vec, model(a, s, sh));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] held, a, s;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #1;
        // R6 reset state
        check_bit("R6 reset valid", out_valid, 1'b0);
        check_bit("R6 reset err", out_err, 1'b0);
        check_vec("R6 reset vec", out_vec, '0);
        @(negedge clk); rst = 1'b0;

        // R1 R8: every legal shift with random distinct lanes
        for (int sh = 1; sh <= 16; sh++)
            beat("R1 R8 sweep", rand_vec(), rand_vec(), 5'(sh));

        // R2: shift 16 threshold at 0x8000
        a = '0; s = '0;
        for (int i = 0; i < NL; i++) begin
            a[16*i +: 16] = 16'(i * 3);
            s[16*i +: 16] = (i % 2 == 0) ? 16'h8000 : 16'h7FFF;
        end
        beat("R2 threshold", a, s, 5'd16);
        for (int sh = 1; sh <= 16; sh++)
            beat("R2 all-ones", rand_vec(), {W{1'b1}}, 5'(sh));

        // R3 wraparound
        beat("R3 wrap", {NL{16'hFFFF}}, {NL{16'h0001}}, 5'd1);
        beat("R3 wrap ones", {NL{16'hFFFE}}, {W{1'b1}}, 5'd3);
        for (int k = 0; k < 8; k++) begin
            a = '0;
            for (int i = 0; i < NL; i++) a[16*i +: 16] = 16'hFFF0 + 16'($urandom_range(15));
            beat("R3 near max", a, rand_vec(), 5'($urandom_range(1, 16)));
        end

        // R4 illegal immediates
        beat("R4 sh0", rand_vec(), rand_vec(), 5'd0);
        beat("R4 sh17", rand_vec(), rand_vec(), 5'd17);
        beat("R4 sh31", rand_vec(), rand_vec(), 5'd31);

        // R5 R7 idle beat with changing inputs
        beat("R1 pre-idle", rand_vec(), rand_vec(), 5'd5);
        held = out_vec;
        @(negedge clk);
        acc_vec = rand_vec(); src_vec = rand_vec(); shamt = 5'd2;
        @(posedge clk); #1;
        check_bit("R5 idle valid", out_valid, 1'b0);
        check_bit("R5 idle err", out_err, 1'b0);
        check_vec("R7 hold", out_vec, held);
        @(posedge clk); #1;
        check_vec("R7 hold second", out_vec, held);

        // random mix
        for (int k = 0; k < 200; k++)
            beat("R1 random", rand_vec(), rand_vec(), 5'($urandom_range(0, 20)));

        // R6 reset during a beat
        @(negedge clk);
        in_valid = 1'b1; acc_vec = rand_vec(); src_vec = rand_vec(); shamt = 5'd0;
        rst = 1'b1;
        @(posedge clk); #1;
        check_bit("R6 mid valid", out_valid, 1'b0);
        check_bit("R6 mid err", out_err, 1'b0);
        check_vec("R6 mid vec", out_vec, '0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        beat("R1 after reset", rand_vec(), rand_vec(), 5'd8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule